// File: doc/BRIEF.md
# Multiplexed Serial Receive Silo

This block is the shared receive path of an eight-line asynchronous serial multiplexer. Each line's receiver offers a character together with parity-error and framing-error flags. The block tags the character with its line number and stores it in one shared 64-entry FIFO (the silo). The host empties the silo by reading a 16-bit receive word. Each read that finds an entry removes it.

The receive word sits at the same address as a write-only line parameter register. A host write to that address sets the speed code, character length, stop bits and parity of one line. A second address holds the control/status word: the scan enable, the receiver interrupt enable, the alarm enable and a self-clearing clear bit.

The block raises an interrupt request when the silo holds work. When alarm mode is on, the request waits until a batch of entries has built up. Characters that cannot be stored are reported through an overrun flag on the next character from the same line that is stored.

Top module: `mux_rx_silo`

## Requirements
- R1: A read of the receive word (reg_sel=1) while the silo holds entries returns the oldest entry, encoded as follows: bit 15 is 1, bits 10:8 hold the line number, bits 7:0 hold the character and bit 11 is 0. That read removes the entry, so entries leave in arrival order.
- R2: Bit 12 of a stored entry copies the line's parity-error input and bit 13 copies its framing-error input, both taken in the cycle the character was offered.
- R3: When a line's character is offered and not stored, the next stored character of that line carries bit 14 (overrun) set. Two causes count: a lower-numbered line won the same cycle, or the silo was full. Later characters from that line carry bit 14 clear.
- R4: When several lines offer a character in the same cycle, only the lowest-numbered line is stored.
- R5: A read of the receive word while the silo is empty returns 0x0000 and changes nothing.
- R6: A write to reg_sel=1 stores parameters for the line in wdata[2:0], and the silo is left untouched. The stored fields are: length wdata[4:3], two-stop wdata[5], parity enable wdata[6], odd parity wdata[7] and speed wdata[11:8]. They appear on line_cfg[9*line +: 9] as {speed[3:0], odd, parity_en, two_stop, len[1:0]}.
- R7: The control/status word (reg_sel=0) holds scan enable in bit 5, receive interrupt enable in bit 6 and alarm enable in bit 12. Reads return these bits and the clear bit 4, with all other bits 0.
- R8: While scan enable is 0, offered characters are neither stored nor counted as lost.
- R9: irq is 1 only while receive interrupt enable is set. With alarm enable clear, a single entry is enough. With alarm enable set, irq needs at least 16 entries.
- R10: Writing bit 4 of the control/status word sets the clear bit for one cycle. At the end of that cycle, the silo is emptied and all line parameters and pending overrun marks are zeroed. After that, bit 4 reads 0.
- R11: The silo holds 64 entries. A character offered while the silo is full is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0: control/status word, 1: receive word / line parameters |
| reg_rd | input | 1 | Host read strobe |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data for the selected address |
| rx_valid | input | 8 | Per-line character offered this cycle |
| rx_char | input | 64 | Per-line character, 8 bits per line |
| rx_perr | input | 8 | Per-line parity error |
| rx_ferr | input | 8 | Per-line framing error |
| line_cfg | output | 72 | Stored line parameters, 9 bits per line |
| irq | output | 1 | Receive interrupt request |

## Verification
A character offered in one cycle is written at the next rising edge. It therefore shows in reg_rdata and irq from the following falling edge. The bench drives inputs and samples outputs only at falling edges.

A receive-word read shows the head entry combinationally in the same cycle. The pop takes effect at the next edge, so each read compares its data before that edge.

Parameter and control writes can be read back one edge after the write. The clear action lands one edge later still, and the bench samples each of those effects exactly in the cycle where it becomes visible.

// File: rtl/mux_rx_silo.sv
module mux_rx_silo #(
  parameter int NLINES = 8,
  parameter int DEPTH  = 64,
  parameter int ALARM  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_sel,
  input  logic                 reg_rd,
  input  logic                 reg_wr,
  input  logic [15:0]          reg_wdata,
  output logic [15:0]          reg_rdata,
  input  logic [NLINES-1:0]    rx_valid,
  input  logic [NLINES*8-1:0]  rx_char,
  input  logic [NLINES-1:0]    rx_perr,
  input  logic [NLINES-1:0]    rx_ferr,
  output logic [NLINES*9-1:0]  line_cfg,
  output logic                 irq
);
  localparam int TAG_W = 3;
  localparam int PRM_W = 9;
  localparam int ENT_W = 8 + TAG_W + 3;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  logic [ENT_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;
  logic [PRM_W-1:0]  cfg [NLINES];
  logic [NLINES-1:0] ovr_pend;
  logic scan_en, rie, sae, clr_q;

  logic             win_vld;
  logic [TAG_W-1:0] win_idx;
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (rx_valid[i]) begin
        win_vld = 1'b1;
        win_idx = TAG_W'(i);
      end
  end

  wire full  = (cnt == CNT_W'(DEPTH));
  wire empty = (cnt == '0);
  wire push  = scan_en && win_vld && !full && !clr_q;
  wire pop   = reg_rd && reg_sel && !empty && !clr_q;

  wire [ENT_W-1:0] new_ent = {ovr_pend[win_idx], rx_ferr[win_idx], rx_perr[win_idx],
                              win_idx, rx_char[win_idx*8 +: 8]};
  wire [ENT_W-1:0] head = mem[rp];

  wire [15:0] rbuf_word = empty ? 16'h0000
                        : {1'b1, head[ENT_W-1 -: 3], 1'b0, head[10:0]};
  wire [15:0] csr_word  = {3'b000, sae, 5'b00000, rie, scan_en, clr_q, 4'b0000};

  assign reg_rdata = reg_sel ? rbuf_word : csr_word;
  assign irq = rie && (sae ? (cnt >= CNT_W'(ALARM)) : !empty);

  always_ff @(posedge clk)
    if (push) mem[wp] <= new_ent;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_q) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_en <= 1'b0;
      rie     <= 1'b0;
      sae     <= 1'b0;
      clr_q   <= 1'b0;
    end else if (reg_wr && !reg_sel) begin
      scan_en <= reg_wdata[5];
      rie     <= reg_wdata[6];
      sae     <= reg_wdata[12];
      clr_q   <= reg_wdata[4];
    end else begin
      clr_q   <= 1'b0;
    end
  end

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (!rst_n || clr_q) begin
          cfg[g]      <= '0;
          ovr_pend[g] <= 1'b0;
        end else begin
          if (reg_wr && reg_sel && reg_wdata[2:0] == TAG_W'(g))
            cfg[g] <= {reg_wdata[11:8], reg_wdata[7], reg_wdata[6], reg_wdata[5], reg_wdata[4:3]};
          if (scan_en && rx_valid[g])
            ovr_pend[g] <= !(push && win_idx == TAG_W'(g));
        end
      end
      assign line_cfg[g*PRM_W +: PRM_W] = cfg[g];
    end
  endgenerate

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  // R11
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !(reg_rd && reg_sel) && !clr_q) |=> full);
  // R10
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (!clr_q && empty));
  // R8
  scan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !clr_q) |=> cnt <= $past(cnt));
  // R1
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel && !empty && rx_valid == '0 && !clr_q) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: tb/mux_rx_silo_tb.sv
module mux_rx_silo_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  rx_valid = '0, rx_perr = '0, rx_ferr = '0;
  logic [63:0] rx_char = '0;
  logic [71:0] line_cfg;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_rx_silo dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_char(rx_char),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .line_cfg(line_cfg), .irq(irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ent(int ln, logic [7:0] ch, logic pe, logic fe, logic ov);
    return {1'b1, ov, fe, pe, 1'b0, 3'(ln), ch};
  endfunction

  task automatic csr_wr(logic [15:0] v);
    reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = v;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic csr_rd(string req, logic [15:0] exp);
    reg_sel = 1'b0;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic put_line(int ln, logic [7:0] ch, logic pe, logic fe, logic ov, bit stored);
    rx_valid[ln] = 1'b1; rx_char[ln*8 +: 8] = ch; rx_perr[ln] = pe; rx_ferr[ln] = fe;
    if (stored) exp_q.push_back(ent(ln, ch, pe, fe, ov));
    tick();
    rx_valid = '0; rx_perr = '0; rx_ferr = '0;
  endtask

  task automatic pop_check(string req);
    logic [15:0] e;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 16'h0000;
    reg_sel = 1'b1; reg_rd = 1'b1;
    #1 chk(req, reg_rdata, e);
    tick();
    reg_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // reset state
    csr_rd("R7 reset csr", 16'h0000);
    chk("R9 reset irq", irq, 0);
    chk("R6 reset cfg", line_cfg, 72'h0);
    reg_sel = 1'b1; #1 chk("R5 reset rbuf", reg_rdata, 16'h0000);
    tick();

    csr_wr(16'h0060);
    csr_rd("R7 csr readback", 16'h0060);

    put_line(3, 8'h41, 1'b1, 1'b0, 1'b0, 1);
    chk("R9 irq single entry", irq, 1);
    pop_check("R1 R2 parity entry");
    chk("R9 irq after drain", irq, 0);

    put_line(7, 8'h5A, 1'b0, 1'b1, 1'b0, 1);
    pop_check("R2 framing entry");

    // R4 and R3: lines 2 and 5 together
    rx_valid[5] = 1'b1; rx_char[5*8 +: 8] = 8'h55;
    put_line(2, 8'h22, 1'b0, 1'b0, 1'b0, 1);
    put_line(5, 8'h66, 1'b0, 1'b0, 1'b1, 1);
    put_line(5, 8'h67, 1'b0, 1'b0, 1'b0, 1);
    pop_check("R4 lowest line wins");
    pop_check("R3 overrun flagged");
    pop_check("R3 overrun cleared");

    pop_check("R5 empty read");
    put_line(0, 8'h10, 1'b0, 1'b0, 1'b0, 1);
    put_line(1, 8'h11, 1'b0, 1'b0, 1'b0, 1);
    pop_check("R1 order first");
    pop_check("R1 order second");

    // R6 parameter write
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 16'h0BFE;
    tick();
    reg_wr = 1'b0;
    chk("R6 line6 cfg", line_cfg[6*9 +: 9], 9'h17F);
    chk("R6 other lines", line_cfg & ~(72'h1FF << 54), 72'h0);
    chk("R6 silo untouched", irq, 0);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 16'h0312;
    tick();
    reg_wr = 1'b0;
    chk("R6 line2 cfg", line_cfg[2*9 +: 9], 9'h062);

    // R8 scan disabled
    csr_wr(16'h0040);
    put_line(3, 8'h99, 1'b0, 1'b0, 1'b0, 0);
    chk("R8 no store irq", irq, 0);
    pop_check("R8 silo empty");
    csr_wr(16'h0060);
    put_line(3, 8'h9A, 1'b0, 1'b0, 1'b0, 1);
    pop_check("R8 no overrun mark");

    // R9 alarm and R11 full
    csr_wr(16'h1060);
    csr_rd("R7 alarm bit", 16'h1060);
    for (int i = 0; i < 15; i++) put_line(i % 8, 8'(i), 1'b0, 1'b0, 1'b0, 1);
    chk("R9 alarm below threshold", irq, 0);
    put_line(1, 8'hF0, 1'b0, 1'b0, 1'b0, 1);
    chk("R9 alarm at threshold", irq, 1);
    for (int i = 16; i < 64; i++) put_line(i % 8, 8'(i), 1'b0, 1'b0, 1'b0, 1);
    put_line(4, 8'hEE, 1'b0, 1'b0, 1'b0, 0);
    for (int i = 0; i < 64; i++) pop_check("R11 full drain");
    pop_check("R11 lost char absent");
    put_line(4, 8'hEF, 1'b0, 1'b0, 1'b1, 1);
    pop_check("R3 overrun after full");

    // R10 clear
    csr_wr(16'h0060);
    rx_valid[1] = 1'b1; rx_char[1*8 +: 8] = 8'h31;
    put_line(0, 8'h30, 1'b0, 1'b0, 1'b0, 0);
    put_line(6, 8'h36, 1'b0, 1'b0, 1'b0, 0);
    csr_wr(16'h0070);
    csr_rd("R10 clear bit visible", 16'h0070);
    tick();
    csr_rd("R10 clear self", 16'h0060);
    chk("R10 cfg zeroed", line_cfg, 72'h0);
    chk("R10 irq", irq, 0);
    pop_check("R10 silo emptied");
    put_line(1, 8'h32, 1'b0, 1'b0, 1'b0, 1);
    pop_check("R10 overrun mark cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule